// File: doc/BRIEF.md
# Sixteen-Function Signed ALU

A combinational arithmetic logic unit for two equal-width two's-complement operands. A four-bit function code picks one of sixteen operations and the block returns the result together with a signed-overflow indication. The operations are signed add and subtract, pass-through and inversion of the first operand, the six two-input bitwise functions, four single-position shifts of the first operand, negation of the first operand, and a constant zero.

The datapath has no clock and no state. Inside, three units run in parallel: an adder/subtractor that also detects overflow, a bitwise unit, and a unit for shifts and other single-operand operations. The upper bits of the function code choose which unit's result reaches the output. The overflow flag can rise only when the adder/subtractor is selected. The operand width is a parameter and defaults to 16 bits.

Top module: `sfalu_top`

## Requirements
- R1: Code 4'b0000 outputs the low bits of a_i + b_i. ovf_o is 1 exactly when a_i and b_i share a sign and the sign of the result differs from it.
- R2: Code 4'b0001 outputs the low bits of a_i − b_i. ovf_o is 1 exactly when a_i and b_i differ in sign and the sign of the result differs from the sign of a_i.
- R3: Code 4'b0010 outputs a_i unchanged. Code 4'b0011 outputs the bitwise inverse of a_i.
- R4: Codes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 output a_i AND b_i, a_i OR b_i, the inverse of the AND, and the inverse of the OR, in that order.
- R5: Code 4'b1000 outputs a_i XOR b_i. Code 4'b1001 outputs its inverse.
- R6: Code 4'b1010 shifts a_i left by one and fills bit 0 with 0. Code 4'b1011 shifts a_i right by one and fills the most significant bit with 0.
- R7: Code 4'b1100 gives the same bit pattern as code 4'b1010. Code 4'b1101 shifts a_i right by one and copies the old sign bit into the most significant bit.
- R8: Code 4'b1110 outputs the two's-complement negation of a_i. The most negative value maps to itself.
- R9: Code 4'b1111 outputs all zeros, whatever the operands are.
- R10: ovf_o is 0 for every code other than 4'b0000 and 4'b0001, including the shifts and negation of the most negative value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | DATA_W (16) | First operand, two's complement |
| b_i | input | DATA_W (16) | Second operand, two's complement |
| op_i | input | 4 | Function code |
| y_o | output | DATA_W (16) | Operation result |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The bench builds the block with the default DATA_W of 16. At that width the signed extremes 32767 and −32768 can be hit both directly and at random, so every overflow boundary is exercised, as is negation of the most negative value. Every function code is crossed with a set of corner operands (0, 1, −1, both extremes and mid-range values), and random codes and operands are added on top. Each result is compared with a reference built from integer arithmetic that is wider than the operands.

// File: rtl/sfalu_pkg.sv
package sfalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_PASS = 4'h2,
    OP_NOT  = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_NAND = 4'h6,
    OP_NOR  = 4'h7,
    OP_XOR  = 4'h8,
    OP_XNOR = 4'h9,
    OP_SHL  = 4'hA,
    OP_SHR  = 4'hB,
    OP_ASL  = 4'hC,
    OP_ASR  = 4'hD,
    OP_NEG  = 4'hE,
    OP_ZERO = 4'hF
  } op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_UNARY = 2'd2
  } cls_e;

  function automatic cls_e op_class(input logic [3:0] op);
    if (op[3:1] == 3'b000) return CLS_ARITH;
    else if (op <= 4'h9)   return CLS_LOGIC;
    else                   return CLS_UNARY;
  endfunction
endpackage

// File: rtl/sfalu_addsub.sv
module sfalu_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + {{(DATA_W-1){1'b0}}, sub};
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end

  // Check: a result one bit wider than the operands must agree with the
  // flag and the low bits.
  logic signed [DATA_W:0] wide;
  always_comb begin
    wide = sub ? ($signed({a[MSB], a}) - $signed({b[MSB], b}))
               : ($signed({a[MSB], a}) + $signed({b[MSB], b}));
    // R1 R2
    ovf_range_chk: assert (ovf == (wide[DATA_W] != wide[MSB]))
      else $error("overflow flag disagrees with widened result");
    // R1 R2
    sum_bits_chk: assert (sum == wide[MSB:0])
      else $error("sum disagrees with widened result");
  end
endmodule

// File: rtl/sfalu_logic.sv
module sfalu_logic
  import sfalu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        op,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_PASS: y = a;
      OP_NOT:  y = ~a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NAND: y = ~(a & b);
      OP_NOR:  y = ~(a | b);
      OP_XOR:  y = a ^ b;
      OP_XNOR: y = ~(a ^ b);
      default: y = '0;
    endcase
  end

  always_comb begin
    // R3
    not_inv_chk: assert (!(op == OP_NOT) || ((y ^ a) == {DATA_W{1'b1}}))
      else $error("NOT result is not the complement");
    // R4
    nand_cover_chk: assert (!(op == OP_NAND) || ((y & a & b) == '0))
      else $error("NAND result overlaps AND");
  end
endmodule

// File: rtl/sfalu_unary.sv
module sfalu_unary
  import sfalu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [3:0]        op,
  output logic [DATA_W-1:0] y
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] shl, shr, asr, neg;

  // One mux cell per output bit; the fill bits at the ends are chosen here.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign shl[i] = 1'b0;
    end else begin : g_lo
      assign shl[i] = a[i-1];
    end
    if (i == MSB) begin : g_hi
      assign shr[i] = 1'b0;
      assign asr[i] = a[MSB];
    end else begin : g_hi
      assign shr[i] = a[i+1];
      assign asr[i] = a[i+1];
    end
  end

  assign neg = (~a) + {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_SHL, OP_ASL: y = shl;
      OP_SHR:         y = shr;
      OP_ASR:         y = asr;
      OP_NEG:         y = neg;
      default:        y = '0;
    endcase
  end

  always_comb begin
    // R7
    asr_sign_chk: assert (!(op == OP_ASR) || (y[MSB] == a[MSB] && y[MSB-1] == a[MSB]))
      else $error("arithmetic right shift lost the sign");
    // R6
    shr_fill_chk: assert (!(op == OP_SHR) || (y[MSB] == 1'b0))
      else $error("logical right shift filled a one");
    // R8
    neg_sum_chk: assert (!(op == OP_NEG) || ((y + a) == '0))
      else $error("negation does not cancel the operand");
  end
endmodule

// File: rtl/sfalu_top.sv
module sfalu_top
  import sfalu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  output logic [DATA_W-1:0] y_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] arith_y, logic_y, unary_y;
  logic              arith_ovf;
  cls_e              cls;

  sfalu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a   (a_i),
    .b   (b_i),
    .sub (op_i[0]),
    .sum (arith_y),
    .ovf (arith_ovf)
  );

  sfalu_logic #(.DATA_W(DATA_W)) u_logic (
    .a  (a_i),
    .b  (b_i),
    .op (op_i),
    .y  (logic_y)
  );

  sfalu_unary #(.DATA_W(DATA_W)) u_unary (
    .a  (a_i),
    .op (op_i),
    .y  (unary_y)
  );

  always_comb begin
    cls = op_class(op_i);
    unique case (cls)
      CLS_ARITH: y_o = arith_y;
      CLS_LOGIC: y_o = logic_y;
      default:   y_o = unary_y;
    endcase
    ovf_o = (cls == CLS_ARITH) && arith_ovf;
  end

  always_comb begin
    // R10
    ovf_scope_chk: assert (!ovf_o || (op_i == OP_ADD) || (op_i == OP_SUB))
      else $error("overflow raised outside add/subtract");
    // R9
    zero_out_chk: assert (!(op_i == OP_ZERO) || (y_o == '0))
      else $error("zero code produced a nonzero result");
  end
endmodule

// File: tb/tb_sfalu_top.sv
module tb_sfalu_top;
  localparam int W = 16;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, y;
  logic [3:0]   op;
  logic         ovf;
  int total = 0;
  int bad = 0;

  sfalu_top #(.DATA_W(W)) dut (
    .a_i(a), .b_i(b), .op_i(op), .y_o(y), .ovf_o(ovf)
  );

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2, 4'h3: return "R3";
      4'h4, 4'h5, 4'h6, 4'h7: return "R4";
      4'h8, 4'h9: return "R5";
      4'hA, 4'hB: return "R6";
      4'hC, 4'hD: return "R7";
      4'hE: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic void ref_alu(input logic [3:0] c, input logic [W-1:0] x,
                                  input logic [W-1:0] z, output logic [W-1:0] r,
                                  output logic v);
    int sx, sz, s;
    sx = $signed(x);
    sz = $signed(z);
    v = 1'b0;
    s = 0;
    case (c)
      4'h0: begin s = sx + sz; r = s[W-1:0]; v = (s > 32767) || (s < -32768); end
      4'h1: begin s = sx - sz; r = s[W-1:0]; v = (s > 32767) || (s < -32768); end
      4'h2: r = x;
      4'h3: r = ~x;
      4'h4: r = x & z;
      4'h5: r = x | z;
      4'h6: r = ~(x & z);
      4'h7: r = ~(x | z);
      4'h8: r = x ^ z;
      4'h9: r = ~(x ^ z);
      4'hA, 4'hC: r = x << 1;
      4'hB: r = x >> 1;
      4'hD: r = {x[W-1], x[W-1:1]};
      4'hE: begin s = -sx; r = s[W-1:0]; end
      default: r = '0;
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W-1:0] er;
    logic ev;
    @(posedge clk);
    op = c; a = x; b = z;
    @(negedge clk);
    ref_alu(c, x, z, er, ev);
    total++;
    if (y !== er) begin
      bad++;
      $display("FAIL %s op=%h a=%h b=%h y=%h expected %h", tag_of(c), c, x, z, y, er);
    end
    total++;
    if (ovf !== ev) begin
      bad++;
      $display("FAIL %s op=%h a=%h b=%h ovf=%b expected %b",
               (c[3:1] == 3'b000) ? tag_of(c) : "R10", c, x, z, ovf, ev);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] corner [6];
    int unused_seed;
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'hFFFF;
    corner[3] = 16'h7FFF; corner[4] = 16'h8000; corner[5] = 16'h4000;
    unused_seed = $urandom(32'd20240611);
    op = '0; a = '0; b = '0;
    // Idle state: all-zero inputs give zero result and no flag (R1)
    apply(4'h0, 16'h0000, 16'h0000);
    // Directed corners for every code (R1..R10)
    for (int c = 0; c < 16; c++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(c[3:0], corner[i], corner[j]);
    // R1 boundary: 32767 + 1 overflows, 32767 + 0 does not
    apply(4'h0, 16'h7FFF, 16'h0001);
    apply(4'h0, 16'h7FFF, 16'h0000);
    // R2 boundary: -32768 - 1 overflows, 0 - (-32768) overflows
    apply(4'h1, 16'h8000, 16'h0001);
    apply(4'h1, 16'h0000, 16'h8000);
    // R8 / R10: negating the most negative value
    apply(4'hE, 16'h8000, 16'h1234);
    // R7 / R10: shifting a value whose top bits differ
    apply(4'hC, 16'h4001, 16'h0000);
    apply(4'hD, 16'h8002, 16'h0000);
    // R9: nonzero operands still give zero
    apply(4'hF, 16'hA5A5, 16'h5A5A);
    // Random sweep
    for (int k = 0; k < 4000; k++)
      apply(4'($urandom % 16), 16'($urandom), 16'($urandom));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule